// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM of 32768 bytes. The host gives a one-cycle request with an address, a write flag and write data. The controller then runs the memory's active-low chip, output and write strobes through a fixed sequence. Every timing margin of the memory is expressed as a whole number of clock cycles, and each of these counts is a parameter. The host learns that an access has finished from a one-cycle done pulse. For reads, the byte arrives on a held read-data output at the same time as the pulse.

The data bus is split into three signals: an outgoing byte, an incoming byte and a drive-enable. The pad ring joins them into the bidirectional pins. A write first holds output enable inactive with the chip selected and waits a bus-release count, so the memory's output drivers can let go of the bus. Only then does the controller drive data. The address is latched for the whole access. Write enable rises while data is still driven, and the drive ends one cycle after that rise. Between accesses chip enable is high, which keeps the memory in standby.

Top module: `async_sram_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, memCeN, memOeN and memWeN are 1, memDrive is 0 and rspDone is 0.
- R2: A read (reqWrite=0) accepted at a clock edge gives, from the next cycle on, exactly ACC_CYC cycles with memCeN=0, memOeN=0, memWeN=1 and memDrive=0, with memAddr equal to the request address.
- R3: Read data is sampled from memDin at the edge that ends the last access cycle. It appears on rspRdata in the done cycle and is held until the next read captures. A byte written to an address is returned by a later read of that address.
- R4: A write (reqWrite=1) starts with exactly HIZ_CYC cycles of memCeN=0, memOeN=1, memWeN=1 and memDrive=0.
- R5: Next come exactly WP_CYC cycles of memWeN=0 with memCeN=0, memOeN=1, memDrive=1 and memDout equal to the request data.
- R6: After memWeN returns to 1 there is exactly one cycle with memCeN=0 and memDrive=1, and the drive ends in the cycle after that.
- R7: memAddr does not change while memCeN stays 0, and memDrive is never 1 while memOeN is 0.
- R8: Each access ends with a single done cycle: rspDone=1 and memCeN=1. The controller is idle in the cycle after it.
- R9: reqValid is acted on only when the controller is idle. A pulse during an access or during its done cycle is ignored: no extra strobes, no extra done pulse and no memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | One-cycle access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write byte |
| rspRdata | output | DATA_W | Last byte read, held |
| rspDone | output | 1 | One-cycle completion pulse |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memAddr | output | ADDR_W | Memory address |
| memDout | output | DATA_W | Byte toward the memory pins |
| memDin | input | DATA_W | Byte from the memory pins |
| memDrive | output | 1 | 1 = controller drives the data pins |

## Verification
Every cycle, the assertions check the bus-safety rules: the controller never drives while output enable is low, write enable is low only while the chip is selected and data is driven, and the address holds while the chip is selected. They also check that done is a lone pulse with the chip deselected and is followed by standby, and that drive continues for the cycle in which write enable rises. The exact phase lengths, the cycle in which read data is captured, data returned after a write, and ignored requests during an access or its done cycle are shown only by the bench's scenarios. The bench's memory model returns valid data only after the full access count.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_DONE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic done;
  } ctlStrobe_t;

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int ACC_CYC = 3,
  parameter int HIZ_CYC = 2,
  parameter int WP_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output ctlStrobe_t strobe
);

  localparam int MAX_AW  = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int MAX_CYC = (HIZ_CYC > MAX_AW) ? HIZ_CYC : MAX_AW;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] HIZ_LAST = CNT_W'(HIZ_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);

  ctlState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             latchReq, capture;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    latchReq = 1'b0;
    capture  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          latchReq = 1'b1;
          cntNxt   = '0;
          stateNxt = reqWrite ? ST_WSETUP : ST_READ;
        end
      end
      ST_READ: begin
        if (cnt == ACC_LAST) begin
          capture  = 1'b1;
          cntNxt   = '0;
          stateNxt = ST_DONE;
        end else begin
          cntNxt = cnt + CNT_W'(1);
        end
      end
      ST_WSETUP: begin
        if (cnt == HIZ_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_WPULSE;
        end else begin
          cntNxt = cnt + CNT_W'(1);
        end
      end
      ST_WPULSE: begin
        if (cnt == WP_LAST) begin
          cntNxt   = '0;
          stateNxt = ST_WHOLD;
        end else begin
          cntNxt = cnt + CNT_W'(1);
        end
      end
      ST_WHOLD: stateNxt = ST_DONE;
      ST_DONE:  stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  // pin levels decoded from the state register only
  always_comb begin
    strobe          = '0;
    strobe.latchReq = latchReq;
    strobe.capture  = capture;
    strobe.ceN      = 1'b1;
    strobe.oeN      = 1'b1;
    strobe.weN      = 1'b1;
    unique case (state)
      ST_READ: begin
        strobe.ceN = 1'b0;
        strobe.oeN = 1'b0;
      end
      ST_WSETUP: strobe.ceN = 1'b0;
      ST_WPULSE: begin
        strobe.ceN   = 1'b0;
        strobe.weN   = 1'b0;
        strobe.drive = 1'b1;
      end
      ST_WHOLD: begin
        strobe.ceN   = 1'b0;
        strobe.drive = 1'b1;
      end
      ST_DONE: strobe.done = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
    end else if (strobe.latchReq) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdataReg <= '0;
    else if (strobe.capture) rdataReg <= memDin;
  end

  assign memAddr  = addrReg;
  assign memDout  = wdataReg;
  assign memCeN   = strobe.ceN;
  assign memOeN   = strobe.oeN;
  assign memWeN   = strobe.weN;
  assign memDrive = strobe.drive;
  assign rspDone  = strobe.done;
  assign rspRdata = rdataReg;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int HIZ_CYC = 2,
  parameter int WP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDrive
);

  ctlStrobe_t strobe;

  sramc_ctrl #(
    .ACC_CYC(ACC_CYC),
    .HIZ_CYC(HIZ_CYC),
    .WP_CYC (WP_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strobe  (strobe)
  );

  sramc_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDin  (memDin),
    .rspRdata(rspRdata),
    .rspDone (rspDone),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memAddr (memAddr),
    .memDout (memDout),
    .memDrive(memDrive)
  );

endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              rspDone,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDrive
);

  AST_NO_DRIVE_INTO_READ: assert property (@(posedge clk) disable iff (!rstN)
    memDrive |-> memOeN); // R7

  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memDrive && memOeN)); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr)); // R7

  AST_DRIVE_PAST_WE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memWeN) && !memCeN) |-> memDrive); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R8

  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (memCeN && !memDrive)); // R8

  AST_STANDBY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> (memCeN && memOeN && memWeN)); // R1

endmodule

bind async_sram_ctrl sramc_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .rspDone (rspDone),
  .memCeN  (memCeN),
  .memOeN  (memOeN),
  .memWeN  (memWeN),
  .memAddr (memAddr),
  .memDrive(memDrive)
);

// File: tb/test_async_sram_ctrl.sv
`timescale 1ns/1ps
module test_async_sram_ctrl;

  localparam int ACC = 3;
  localparam int HIZ = 2;
  localparam int WP  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rspRdata;
  logic        rspDone, memCeN, memOeN, memWeN, memDrive;
  logic [14:0] memAddr;
  logic [7:0]  memDout, memDin;

  always #2 clk = ~clk;

  async_sram_ctrl #(.ACC_CYC(ACC), .HIZ_CYC(HIZ), .WP_CYC(WP)) i_async_sram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata), .rspDone(rspDone),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDout(memDout), .memDin(memDin), .memDrive(memDrive)
  );

  // device model: data is valid only after the full access time
  logic [7:0] devMem [0:32767];
  int         readCycles = 0;
  logic [14:0] lastRdAddr = '0;
  wire readOn = !memCeN && !memOeN && memWeN && !memDrive;
  assign memDin = (readOn && readCycles >= ACC - 1) ? devMem[memAddr] : 8'h5A;
  always @(posedge clk) begin
    if (readOn && (readCycles == 0 || memAddr == lastRdAddr)) readCycles <= readCycles + 1;
    else readCycles <= 0;
    lastRdAddr <= memAddr;
    if (!memWeN && !memCeN) devMem[memAddr] <= memDrive ? memDout : 8'hEE;
  end

  // reference model
  typedef struct {
    logic ceN, oeN, weN, drive, done;
    logic [14:0] addr;
    logic [7:0] dout;
    logic [7:0] rdata;
    string tag;
  } phase_t;

  phase_t     expQ[$];
  logic [7:0] refMem [0:32767];
  logic [7:0] lastRd = 8'h00;
  int checks = 0, fails = 0, doneSeen = 0;

  function automatic phase_t mk(logic c, logic o, logic w, logic dr, logic dn,
                                logic [14:0] a, logic [7:0] d, logic [7:0] r, string t);
    phase_t p;
    p.ceN = c; p.oeN = o; p.weN = w; p.drive = dr; p.done = dn;
    p.addr = a; p.dout = d; p.rdata = r; p.tag = t;
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input phase_t e);
    check({memCeN, memOeN, memWeN} == {e.ceN, e.oeN, e.weN}, e.tag, "ce/oe/we",
          {29'd0, memCeN, memOeN, memWeN}, {29'd0, e.ceN, e.oeN, e.weN});
    check(memDrive == e.drive, e.tag, "drive", {31'd0, memDrive}, {31'd0, e.drive});
    check(rspDone == e.done, "R8", "done", {31'd0, rspDone}, {31'd0, e.done});
    if (!e.ceN) check(memAddr == e.addr, "R7", "address", {17'd0, memAddr}, {17'd0, e.addr});
    if (e.drive) check(memDout == e.dout, "R5", "write data", {24'd0, memDout}, {24'd0, e.dout});
    check(rspRdata == e.rdata, "R3", "read data", {24'd0, rspRdata}, {24'd0, e.rdata});
  endtask

  task automatic tick(input logic v, input logic w, input logic [14:0] a, input logic [7:0] d);
    phase_t e;
    bit     idleNow;
    @(negedge clk);
    idleNow = (expQ.size() == 0);
    if (idleNow) e = mk(1, 1, 1, 0, 0, '0, '0, lastRd, "R1/R9");
    else         e = expQ.pop_front();
    compare(e);
    if (e.done) doneSeen++;
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    if (v && idleNow) begin
      if (w) begin
        refMem[a] = d;
        for (int i = 0; i < HIZ; i++) expQ.push_back(mk(0, 1, 1, 0, 0, a, d, lastRd, "R4"));
        for (int i = 0; i < WP; i++)  expQ.push_back(mk(0, 1, 0, 1, 0, a, d, lastRd, "R5"));
        expQ.push_back(mk(0, 1, 1, 1, 0, a, d, lastRd, "R6"));
        expQ.push_back(mk(1, 1, 1, 0, 1, a, d, lastRd, "R8"));
      end else begin
        for (int i = 0; i < ACC; i++) expQ.push_back(mk(0, 0, 1, 0, 0, a, d, lastRd, "R2"));
        lastRd = refMem[a];
        expQ.push_back(mk(1, 1, 1, 0, 1, a, d, lastRd, "R8"));
      end
    end
  endtask

  // one access; optional ignored pulses during the access and in its done cycle
  task automatic access(input logic w, input logic [14:0] a, input logic [7:0] d, input bit noisy);
    doneSeen = 0;
    tick(1, w, a, d);
    tick(noisy, 1'b1, a ^ 15'h0200, 8'h99);
    while (expQ.size() > 1) tick(0, 0, '0, '0);
    tick(noisy, 1'b1, a ^ 15'h0300, 8'h77);
    tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);
    check(doneSeen == 1, "R9", "done pulses per access", doneSeen, 1);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=%h exp=%h", 1, 0);
    report();
  end

  initial begin
    for (int i = 0; i < 32768; i++) begin devMem[i] = 8'h00; refMem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check({memCeN, memOeN, memWeN, memDrive, rspDone} == 5'b11100, "R1", "reset pins",
          {27'd0, memCeN, memOeN, memWeN, memDrive, rspDone}, 32'h1C);
    rstN = 1'b1;
    repeat (3) tick(0, 0, '0, '0);
    // writes to boundaries and middle (R4 R5 R6)
    access(1, 15'h0000, 8'h3C, 0);
    access(1, 15'h7FFF, 8'hC3, 0);
    access(1, 15'h1234, 8'hA7, 0);
    // read after write, then read after read (R2 R3)
    access(0, 15'h7FFF, 8'h00, 0);
    access(0, 15'h0000, 8'h00, 0);
    access(0, 15'h1234, 8'h00, 0);
    // ignored pulses during busy and done cycle (R9)
    access(1, 15'h0100, 8'h11, 1);
    access(0, 15'h0100, 8'h00, 1);
    access(0, 15'h0300, 8'h00, 0);
    access(0, 15'h0000, 8'h00, 0);
    // overwrite
    access(1, 15'h1234, 8'hE1, 0);
    access(0, 15'h1234, 8'h00, 0);
    // pattern sweep
    for (int i = 0; i < 8; i++) access(1, 15'((i * 4099) & 32767), 8'((i * 37) + 1), 0);
    for (int i = 7; i >= 0; i--) access(0, 15'((i * 4099) & 32767), 8'h00, 0);
    repeat (4) tick(0, 0, '0, '0);
    report();
  end

endmodule